// File: doc/BRIEF.md
# Dual-Mode Signed Embedded Multiplier

This block is a fixed-function multiplier of the kind placed as a hard macro next to a logic fabric. In full mode it multiplies two 18-bit operands into a 36-bit product. In split mode the same datapath works as two independent 9x9 multipliers. Their two 18-bit products are packed side by side into the 36-bit result. The mode is chosen per operation by an input pin, so a stream can mix both kinds of operation cycle by cycle.

Two run-time controls set how each operand is read. When an operand's control is set, it is a two's-complement value. When it is clear, it is an unsigned value. A signed operand may be multiplied by an unsigned one, and the result is exact. Two elaboration parameters set whether an input register stage and an output register stage are present, so the latency is 0, 1 or 2 clock cycles. The mode and sign controls travel through the same stages as the operands. An asynchronous clear zeroes every stage that is present.

Top module: `dm_mul`

## Requirements
- R1: With `split_mode` = 0 and both sign controls low, `prod` is the exact unsigned 36-bit product of `x_in` and `y_in`. For example, 0x3FFFF times 0x3FFFF gives 0xFFFF80001.
- R2: With `split_mode` = 0, `x_signed` = 1 makes `x_in` a two's-complement value and `y_signed` = 1 does the same for `y_in`. The result is the signed product in 36-bit two's complement. For example, -131072 times -131072 gives 0x400000000.
- R3: Mixed signed-by-unsigned products are exact. For example, `x_in` = 0x3FFFF signed (-1) times `y_in` = 0x3FFFF unsigned gives 0xFFFFC0001.
- R4: With `split_mode` = 1, `prod[17:0]` is the 18-bit product of `x_in[8:0]` and `y_in[8:0]`, and `prod[35:18]` is the 18-bit product of `x_in[17:9]` and `y_in[17:9]`.
- R5: In split mode the two half-products are independent. Changing the upper 9 bits of either operand leaves `prod[17:0]` unchanged, and the reverse also holds.
- R6: In split mode, `x_signed` marks both 9-bit halves of `x_in` as signed and `y_signed` does the same for `y_in`. For example, 0x100 times 0x100 with both signed gives 0x10000, and 0x1FF signed times 0x1FF unsigned gives 0x3FE01.
- R7: The latency from the inputs to `prod` is exactly `IN_REG` + `OUT_REG` clock edges (2 by default). `split_mode` and the sign controls are delayed together with their operands, and `prod` does not change one cycle early.
- R8: `clr` is asynchronous and active high, and it zeroes every register stage. While it is high, `prod` is 0 whenever any stage is present. With both stages present, the first edge after release still gives 0, because the input stage holds zeros.
- R9: Any operand equal to zero gives a zero product in full mode, regardless of the sign controls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional register stages |
| clr | input | 1 | Asynchronous active-high clear of all stages |
| x_in | input | 18 | Operand X (two 9-bit halves in split mode) |
| y_in | input | 18 | Operand Y (two 9-bit halves in split mode) |
| x_signed | input | 1 | 1: X (or each X half) is two's complement |
| y_signed | input | 1 | 1: Y (or each Y half) is two's complement |
| split_mode | input | 1 | 0: one 18x18 multiply, 1: two 9x9 multiplies |
| prod | output | 36 | Product, or {high half-product, low half-product} |

## Verification
The bench aims at the extreme operands: the most negative value squared, all-ones unsigned squared, and all-ones read as -1 against all-ones read as unsigned. A sign-extension error in any of these shows up as a wrong upper product word. In split mode, high-half values are chosen so that a carry or sign leaking across bit 17/18 would corrupt the other lane. Signedness is also varied per half, to catch a design that applies the sign only to the top half. Mode and sign controls are toggled from one cycle to the next, so controls that are not delayed with their operands produce mismatched results. The bench also checks that the result does not appear a cycle early, and that the clear zeroes the input stage as well as the output.

// File: rtl/dm_mul_pkg.sv
package dm_mul_pkg;

    typedef enum logic {
        MUL_FULL  = 1'b0,
        MUL_SPLIT = 1'b1
    } mul_mode_e;

endpackage

// File: rtl/dm_mul_inreg.sv
module dm_mul_inreg
    import dm_mul_pkg::*;
#(
    parameter int W  = 18,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         clr,
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         sx_i,
    input  logic         sy_i,
    input  mul_mode_e    mode_i,
    output logic [W-1:0] x_o,
    output logic [W-1:0] y_o,
    output logic         sx_o,
    output logic         sy_o,
    output mul_mode_e    mode_o
);

    typedef struct packed {
        logic [W-1:0] x;
        logic [W-1:0] y;
        logic         sx;
        logic         sy;
        mul_mode_e    mode;
    } op_t;

    generate
        if (EN) begin : g_reg
            op_t st_d, st_q;

            always_comb begin
                st_d.x    = x_i;
                st_d.y    = y_i;
                st_d.sx   = sx_i;
                st_d.sy   = sy_i;
                st_d.mode = mode_i;
            end

            always_ff @(posedge clk or posedge clr) begin
                if (clr) st_q <= '0;
                else     st_q <= st_d;
            end

            assign x_o    = st_q.x;
            assign y_o    = st_q.y;
            assign sx_o   = st_q.sx;
            assign sy_o   = st_q.sy;
            assign mode_o = st_q.mode;
        end else begin : g_pass
            assign x_o    = x_i;
            assign y_o    = y_i;
            assign sx_o   = sx_i;
            assign sy_o   = sy_i;
            assign mode_o = mode_i;
        end
    endgenerate

endmodule

// File: rtl/dm_mul_lane.sv
module dm_mul_lane #(
    parameter int AW = 9
) (
    input  logic [AW-1:0]   a,
    input  logic [AW-1:0]   b,
    input  logic            a_sgn,
    input  logic            b_sgn,
    output logic [2*AW-1:0] p
);

    localparam int PW = 2 * AW;

    logic signed [AW:0]   ea, eb;
    logic signed [PW-1:0] wa, wb;

    always_comb begin
        ea = $signed({a_sgn & a[AW-1], a});
        eb = $signed({b_sgn & b[AW-1], b});
        wa = PW'(ea);
        wb = PW'(eb);
        p  = wa * wb;
    end

endmodule

// File: rtl/dm_mul_array.sv
module dm_mul_array
    import dm_mul_pkg::*;
#(
    parameter int HALF_W = 9
) (
    input  logic [2*HALF_W-1:0] x,
    input  logic [2*HALF_W-1:0] y,
    input  logic                sx,
    input  logic                sy,
    input  mul_mode_e           mode,
    output logic [4*HALF_W-1:0] p
);

    localparam int W   = 2 * HALF_W;
    localparam int PW  = 2 * W;
    localparam int HPW = 2 * HALF_W;

    logic [PW-1:0]  full_p;
    logic [HPW-1:0] half_p [0:1];

    dm_mul_lane #(.AW(W)) u_full (
        .a     (x),
        .b     (y),
        .a_sgn (sx),
        .b_sgn (sy),
        .p     (full_p)
    );

    generate
        for (genvar g = 0; g < 2; g++) begin : g_half
            dm_mul_lane #(.AW(HALF_W)) u_half (
                .a     (x[g*HALF_W +: HALF_W]),
                .b     (y[g*HALF_W +: HALF_W]),
                .a_sgn (sx),
                .b_sgn (sy),
                .p     (half_p[g])
            );
        end
    endgenerate

    always_comb begin
        if (mode == MUL_SPLIT) p = {half_p[1], half_p[0]};
        else                   p = full_p;
    end

endmodule

// File: rtl/dm_mul_outreg.sv
module dm_mul_outreg #(
    parameter int PW = 36,
    parameter bit EN = 1'b1
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [PW-1:0] p_i,
    output logic [PW-1:0] p_o
);

    generate
        if (EN) begin : g_reg
            logic [PW-1:0] p_d, p_q;

            always_comb p_d = p_i;

            always_ff @(posedge clk or posedge clr) begin
                if (clr) p_q <= '0;
                else     p_q <= p_d;
            end

            assign p_o = p_q;
        end else begin : g_pass
            assign p_o = p_i;
        end
    endgenerate

endmodule

// File: rtl/dm_mul.sv
module dm_mul
    import dm_mul_pkg::*;
#(
    parameter int HALF_W  = 9,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                clk,
    input  logic                clr,
    input  logic [2*HALF_W-1:0] x_in,
    input  logic [2*HALF_W-1:0] y_in,
    input  logic                x_signed,
    input  logic                y_signed,
    input  logic                split_mode,
    output logic [4*HALF_W-1:0] prod
);

    localparam int W  = 2 * HALF_W;
    localparam int PW = 2 * W;

    logic [W-1:0]  xr, yr;
    logic          sxr, syr;
    mul_mode_e     mode_in, mode_r;
    logic [PW-1:0] arr_p;

    assign mode_in = split_mode ? MUL_SPLIT : MUL_FULL;

    dm_mul_inreg #(.W(W), .EN(IN_REG)) u_inreg (
        .clk    (clk),
        .clr    (clr),
        .x_i    (x_in),
        .y_i    (y_in),
        .sx_i   (x_signed),
        .sy_i   (y_signed),
        .mode_i (mode_in),
        .x_o    (xr),
        .y_o    (yr),
        .sx_o   (sxr),
        .sy_o   (syr),
        .mode_o (mode_r)
    );

    dm_mul_array #(.HALF_W(HALF_W)) u_array (
        .x    (xr),
        .y    (yr),
        .sx   (sxr),
        .sy   (syr),
        .mode (mode_r),
        .p    (arr_p)
    );

    dm_mul_outreg #(.PW(PW), .EN(OUT_REG)) u_outreg (
        .clk (clk),
        .clr (clr),
        .p_i (arr_p),
        .p_o (prod)
    );

endmodule

// File: rtl/dm_mul_chk.sv
module dm_mul_chk #(
    parameter int HALF_W  = 9,
    parameter bit IN_REG  = 1'b1,
    parameter bit OUT_REG = 1'b1
) (
    input logic                clk,
    input logic                clr,
    input logic [2*HALF_W-1:0] x_in,
    input logic [2*HALF_W-1:0] y_in,
    input logic                x_signed,
    input logic                y_signed,
    input logic                split_mode,
    input logic [4*HALF_W-1:0] prod
);

    localparam int W   = 2 * HALF_W;
    localparam int PW  = 2 * W;
    localparam int HPW = 2 * HALF_W;
    localparam int LAT = int'(IN_REG) + int'(OUT_REG);
    localparam int VW  = 2 * W + 3;

    logic [VW-1:0] cur, s1, s2, tap;
    logic [1:0]    warm_cnt;
    logic          warm;

    assign cur = {split_mode, y_signed, x_signed, y_in, x_in};

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            s1       <= '0;
            s2       <= '0;
            warm_cnt <= '0;
        end else begin
            s1 <= cur;
            s2 <= s1;
            if (int'(warm_cnt) < LAT) warm_cnt <= warm_cnt + 2'd1;
        end
    end

    generate
        if (LAT == 0)      begin : g_t0 assign tap = cur; end
        else if (LAT == 1) begin : g_t1 assign tap = s1;  end
        else               begin : g_t2 assign tap = s2;  end
    endgenerate

    assign warm = (int'(warm_cnt) == LAT);

    logic [W-1:0]  tx, ty;
    logic          tsx, tsy, tsp;
    logic signed [PW-1:0] xs_w, ys_w;
    logic [HPW-1:0] lo_u, hi_u;

    assign tx   = tap[W-1:0];
    assign ty   = tap[2*W-1:W];
    assign tsx  = tap[2*W];
    assign tsy  = tap[2*W+1];
    assign tsp  = tap[2*W+2];
    assign xs_w = PW'($signed(tx));
    assign ys_w = PW'($signed(ty));
    assign lo_u = HPW'(tx[HALF_W-1:0]) * HPW'(ty[HALF_W-1:0]);
    assign hi_u = HPW'(tx[W-1:HALF_W]) * HPW'(ty[W-1:HALF_W]);

    // R1
    full_unsigned_chk: assert property (@(posedge clk) disable iff (clr)
        (warm && !tsp && !tsx && !tsy) |-> (prod == PW'(tx) * PW'(ty)));

    // R2
    full_signed_chk: assert property (@(posedge clk) disable iff (clr)
        (warm && !tsp && tsx && tsy) |-> ($signed(prod) == xs_w * ys_w));

    // R4
    split_low_chk: assert property (@(posedge clk) disable iff (clr)
        (warm && tsp && !tsx && !tsy) |-> (prod[HPW-1:0] == lo_u));

    // R5
    split_high_chk: assert property (@(posedge clk) disable iff (clr)
        (warm && tsp && !tsx && !tsy) |-> (prod[PW-1:HPW] == hi_u));

    // R9
    zero_operand_chk: assert property (@(posedge clk) disable iff (clr)
        (warm && !tsp && (tx == '0 || ty == '0)) |-> (prod == '0));

    generate
        if (LAT > 0) begin : g_clr
            // R8
            clear_zero_chk: assert property (@(posedge clk)
                clr |-> (prod == '0));
        end
    endgenerate

endmodule

bind dm_mul dm_mul_chk #(
    .HALF_W  (HALF_W),
    .IN_REG  (IN_REG),
    .OUT_REG (OUT_REG)
) u_chk (
    .clk        (clk),
    .clr        (clr),
    .x_in       (x_in),
    .y_in       (y_in),
    .x_signed   (x_signed),
    .y_signed   (y_signed),
    .split_mode (split_mode),
    .prod       (prod)
);

// File: tb/dm_mul_tb.sv
`timescale 1ns/1ps
module dm_mul_tb;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        clr = 1'b1;
    logic [17:0] x_in = '0;
    logic [17:0] y_in = '0;
    logic        x_signed = 1'b0;
    logic        y_signed = 1'b0;
    logic        split_mode = 1'b0;
    logic [35:0] prod;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    typedef struct {
        logic [35:0] exp;
        string       req;
        int          due;
    } item_t;

    item_t sb[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dm_mul u_dut (
        .clk        (clk),
        .clr        (clr),
        .x_in       (x_in),
        .y_in       (y_in),
        .x_signed   (x_signed),
        .y_signed   (y_signed),
        .split_mode (split_mode),
        .prod       (prod)
    );

    function automatic longint opval(logic [17:0] v, int w, bit s);
        longint r;
        r = longint'(v) & ((longint'(1) << w) - 1);
        if (s && v[w-1]) r = r - (longint'(1) << w);
        return r;
    endfunction

    function automatic logic [35:0] model(logic [17:0] a, logic [17:0] b,
                                          bit sa, bit sb_, bit sp);
        longint pl, ph;
        if (!sp) begin
            pl = opval(a, 18, sa) * opval(b, 18, sb_);
            return pl[35:0];
        end
        pl = opval(a[8:0], 9, sa) * opval(b[8:0], 9, sb_);
        ph = opval(a[17:9], 9, sa) * opval(b[17:9], 9, sb_);
        return {ph[17:0], pl[17:0]};
    endfunction

    task automatic check(logic [35:0] act, logic [35:0] exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(logic [17:0] a, logic [17:0] b, bit sa, bit sb_,
                         bit sp, string req);
        item_t it;
        @(negedge clk);
        x_in = a; y_in = b; x_signed = sa; y_signed = sb_; split_mode = sp;
        it.exp = model(a, b, sa, sb_, sp);
        it.req = req;
        it.due = cyc + LAT;
        sb.push_back(it);
    endtask

    task automatic flush();
        for (int i = 0; i < LAT + 2; i++) drive('0, '0, 0, 0, 0, "R9");
        repeat (LAT + 1) @(negedge clk);
    endtask

    // monitor: pops expected items when due
    always @(negedge clk) begin
        item_t it;
        #1;
        if (sb.size() > 0 && sb[0].due == cyc) begin
            it = sb.pop_front();
            check(prod, it.exp, it.req);
        end
    end

    task automatic finish_sim();
        if (!done) begin
            done = 1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_sim();
    end

    initial begin
        // R8: reset state
        #12;
        check(prod, '0, "R8 reset");
        @(negedge clk); clr = 1'b0;

        // R1 unsigned full
        drive(18'h3FFFF, 18'h3FFFF, 0, 0, 0, "R1 max");
        drive(18'h12345, 18'h00ABC, 0, 0, 0, "R1");
        // R2 signed full
        drive(18'h20000, 18'h20000, 1, 1, 0, "R2 min*min");
        drive(18'h3FFFE, 18'h00007, 1, 1, 0, "R2");
        // R3 mixed
        drive(18'h3FFFF, 18'h3FFFF, 1, 0, 0, "R3 -1*max");
        drive(18'h0FFFF, 18'h20000, 0, 1, 0, "R3");
        // R4 split unsigned
        drive({9'h1FF, 9'h1FF}, {9'h1FF, 9'h1FF}, 0, 0, 1, "R4");
        drive({9'h003, 9'h010}, {9'h005, 9'h020}, 0, 0, 1, "R4");
        // R5 independence: same low halves, different high halves
        drive({9'h0AA, 9'h055}, {9'h133, 9'h0F0}, 0, 0, 1, "R5 a");
        drive({9'h1FF, 9'h055}, {9'h1FF, 9'h0F0}, 1, 1, 1, "R5 b");
        // R6 split signed per half
        drive({9'h100, 9'h100}, {9'h100, 9'h100}, 1, 1, 1, "R6 min*min");
        drive({9'h1FF, 9'h1FF}, {9'h1FF, 9'h1FF}, 1, 0, 1, "R6 mixed");
        drive({9'h001, 9'h1FF}, {9'h1FF, 9'h002}, 0, 1, 1, "R6");
        // R7 back-to-back mode and sign toggling
        drive(18'h3FFFF, 18'h3FFFF, 1, 1, 0, "R7 toggle full");
        drive(18'h3FFFF, 18'h3FFFF, 1, 1, 1, "R7 toggle split");
        drive(18'h3FFFF, 18'h3FFFF, 0, 0, 1, "R7 toggle split u");
        // R9 zero operand
        drive(18'h00000, 18'h2ABCD, 1, 1, 0, "R9");
        drive(18'h3FFFF, 18'h00000, 1, 0, 0, "R9");
        flush();

        // R7: result must not show one cycle early
        drive(18'h00100, 18'h00100, 0, 0, 0, "R7 on time");
        @(negedge clk);
        #2 check(prod, '0, "R7 not early");
        flush();

        // R8: asynchronous clear mid-stream
        @(negedge clk);
        x_in = 18'h01234; y_in = 18'h00056; x_signed = 0; y_signed = 0; split_mode = 0;
        @(posedge clk); @(posedge clk);
        #2 check(prod, model(18'h01234, 18'h00056, 0, 0, 0), "R8 pre-clear");
        #1 clr = 1'b1;
        #1 check(prod, '0, "R8 async clear");
        @(negedge clk); clr = 1'b0;
        @(negedge clk);
        #1 check(prod, '0, "R8 input stage zeroed");
        @(negedge clk);
        #1 check(prod, model(18'h01234, 18'h00056, 0, 0, 0), "R8 recovery");

        repeat (4) @(negedge clk);
        finish_sim();
    end

endmodule